// File: doc/BRIEF.md
# Soft-Decision Block Decoder for 26-Bit Radio Data Blocks

This block accepts one received 26-bit block (16 data bits followed by 10 check bits) together with an 8-bit reliability value for every bit. It returns the 16 data bits and the offset kind of the block, or a failure indication. First it checks the unmodified word. If that check fails, it walks through every single-bit flip and then every two-bit flip. It keeps the valid trial whose flipped bits have the smallest total reliability.

The search is sequential and tests one trial per clock. A `start` pulse loads the word and the reliabilities. `busy` stays high while the search runs. A one-cycle `done` pulse marks the moment the results become valid, and the results then hold until the next accepted start. The upstream demodulator supplies the reliabilities, and the consumer of `done` handles group assembly.

Top module: `rds_soft_block_dec`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done` and `ok` are 0, `data_out` and `kind_out` are 0 and `cost_out` is 511.
- R2: If the received word is itself a valid block, the result is `ok`=1, `data_out`=word[25:10] and `cost_out`=0.
- R3: Validity and kind use the remainder of the 26-bit word divided by x^10+x^8+x^7+x^5+x^4+x^3+1. Each remainder maps to a `kind_out` code: 0x0FC gives 0 (A), 0x198 gives 1 (B), 0x168 gives 2 (C), 0x350 gives 3 (C') and 0x1B4 gives 4 (D). Any other remainder is invalid.
- R4: If the word is invalid, all 26 single flips are tried. Index k toggles word bit 25-k and costs `conf_in[8k+7:8k]`. The valid flip with the lowest cost wins, and `cost_out` carries that cost.
- R5: If any single flip is valid, no two-bit flip is considered, even one that would cost less.
- R6: If no single flip is valid, all 325 pairs i<j are tried at a cost of conf(i)+conf(j), and the valid pair with the lowest cost wins.
- R7: When two trials have equal cost, the result comes from the one found first. Singles are searched in ascending k. Pairs are searched in ascending i, then ascending j.
- R8: If no trial is valid, `ok`=0, `data_out`=0, `kind_out`=0 and `cost_out`=511.
- R9: `start` is accepted only while `busy` is 0. `busy` rises the cycle after an accepted start and falls when `done` pulses. `done` lasts one cycle. A `start` raised while busy is ignored. Results hold until the next accepted start.
- R10: `cost_out` is 9 bits wide, so a pair of two 255 reliabilities reports 510 without wrapping.
- R11: `done` comes 1 cycle after the start edge for a valid word, 27 cycles for a single-flip result, and 352 cycles otherwise. Pairs skipped by cost pruning still take a cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to decode the presented word |
| word_in | input | 26 | Received block, bit 25 first on air |
| conf_in | input | 208 | Reliability of index k in bits [8k+7:8k] |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ok | output | 1 | A valid block was found |
| data_out | output | 16 | Decoded data bits |
| kind_out | output | 3 | Offset kind code |
| cost_out | output | 9 | Summed reliability of flipped bits |

## Verification
A wrong best-cost or found register would show up at the ports in three ways: a larger `cost_out` than the cheapest valid trial, a different kind or data word, or a wrongly reported failure. All of these appear at the `done` pulse of the same request. A fault in the index walker would change the tie-break result, or would move the `done` pulse away from cycle 1, 27 or 352. Both effects can be measured on the first request that reaches the affected search stage. A handshake fault would show up as a result that follows a start raised while busy.

// File: rtl/rdsdec_pkg.sv
// Shared constants, types and check-word arithmetic for the soft block decoder.
// Assumes the fixed block layout: 16 data bits above 10 check bits.
package rdsdec_pkg;

    localparam int BLK_W = 26;
    localparam int DAT_W = 16;
    localparam int CHK_W = BLK_W - DAT_W;
    localparam int N_KIND = 5;

    // Generator polynomial without its leading x^10 term.
    localparam logic [CHK_W-1:0] GEN_LOW = 10'h1B9;

    typedef enum logic [2:0] {
        KIND_A  = 3'd0,
        KIND_B  = 3'd1,
        KIND_C  = 3'd2,
        KIND_CP = 3'd3,
        KIND_D  = 3'd4
    } blk_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_D0,
        ST_D1,
        ST_D2
    } dec_state_e;

    localparam logic [N_KIND*CHK_W-1:0] OFFSET_TABLE = {
        10'h1B4, 10'h350, 10'h168, 10'h198, 10'h0FC
    };

    // Remainder of data * x^10 divided by the generator polynomial.
    function automatic logic [CHK_W-1:0] check_bits(input logic [DAT_W-1:0] d);
        logic [CHK_W-1:0] r;
        logic fb;
        r = '0;
        for (int i = DAT_W - 1; i >= 0; i--) begin
            fb = d[i] ^ r[CHK_W-1];
            r  = {r[CHK_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

endpackage

// File: rtl/rdsdec_syndrome.sv
// Combinational validity test of one 26-bit trial word.
// Reports whether the syndrome matches one of the offset words and which one.
module rdsdec_syndrome
    import rdsdec_pkg::*;
(
    input  logic [BLK_W-1:0] trial,
    output logic             hit,
    output blk_kind_e        kind,
    output logic [DAT_W-1:0] data
);

    logic [CHK_W-1:0] syn;

    assign data = trial[BLK_W-1:CHK_W];
    assign syn  = trial[CHK_W-1:0] ^ check_bits(trial[BLK_W-1:CHK_W]);

    // Match the syndrome against every offset word.
    always_comb begin
        hit  = 1'b0;
        kind = KIND_A;
        for (int n = 0; n < N_KIND; n++) begin
            if (!hit && syn == OFFSET_TABLE[n*CHK_W +: CHK_W]) begin
                hit  = 1'b1;
                kind = blk_kind_e'(n);
            end
        end
    end

endmodule

// File: rtl/rdsdec_idx_walk.sv
// Index walker: counts single indices 0..N-1 or unordered pairs (a<b) in
// lexicographic order. Assumes the caller steps only in the matching mode.
module rdsdec_idx_walk #(
    parameter int N = 26,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_single,
    input  logic          clr_pair,
    input  logic          step_single,
    input  logic          step_pair,
    output logic [IW-1:0] idx_a,
    output logic [IW-1:0] idx_b,
    output logic          last_single,
    output logic          last_pair
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // Advance the single index or the pair of indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_a <= '0;
            idx_b <= IW'(1);
        end else if (clr_single) begin
            idx_a <= '0;
        end else if (clr_pair) begin
            idx_a <= '0;
            idx_b <= IW'(1);
        end else if (step_single) begin
            idx_a <= idx_a + IW'(1);
        end else if (step_pair) begin
            if (idx_b == LAST) begin
                idx_a <= idx_a + IW'(1);
                idx_b <= idx_a + IW'(2);
            end else begin
                idx_b <= idx_b + IW'(1);
            end
        end
    end

    assign last_single = (idx_a == LAST);
    assign last_pair   = (idx_a == LAST - IW'(1)) && (idx_b == LAST);

endmodule

// File: rtl/rds_soft_block_dec.sv
// Soft-decision decoder for one 26-bit block. The search runs in three stages:
// distance 0, then the 26 single flips, then the 325 pairs, testing one trial
// per cycle. The cheapest valid trial wins and ties keep the earliest trial.
// Assumes the inputs stay stable only in the start cycle, because they are latched there.
module rds_soft_block_dec
    import rdsdec_pkg::*;
#(
    parameter int CONF_W = 8,
    localparam int COST_W = CONF_W + 1,
    localparam int IW = $clog2(BLK_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BLK_W-1:0]        word_in,
    input  logic [BLK_W*CONF_W-1:0] conf_in,
    output logic                    busy,
    output logic                    done,
    output logic                    ok,
    output logic [DAT_W-1:0]        data_out,
    output logic [2:0]              kind_out,
    output logic [COST_W-1:0]       cost_out
);

    localparam logic [COST_W-1:0] COST_NONE = '1;
    localparam logic [BLK_W-1:0]  ONE_HOT0  = BLK_W'(1);

    dec_state_e        state;
    logic [BLK_W-1:0]  word_q;
    logic [CONF_W-1:0] conf_q [BLK_W];
    logic              best_found;
    logic [COST_W-1:0] best_cost;
    logic [DAT_W-1:0]  best_data;
    blk_kind_e         best_kind;

    logic [IW-1:0]     idx_a, idx_b;
    logic              last_single, last_pair;
    logic [BLK_W-1:0]  trial;
    logic [COST_W-1:0] trial_cost;
    logic              syn_hit;
    blk_kind_e         syn_kind;
    logic [DAT_W-1:0]  syn_data;
    logic              prune, take;
    logic              nxt_found;
    logic [COST_W-1:0] nxt_cost;
    logic [DAT_W-1:0]  nxt_data;
    blk_kind_e         nxt_kind;

    rdsdec_idx_walk #(.N(BLK_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_single  (state == ST_IDLE),
        .clr_pair    (state == ST_D1 && last_single),
        .step_single (state == ST_D1 && !last_single),
        .step_pair   (state == ST_D2),
        .idx_a       (idx_a),
        .idx_b       (idx_b),
        .last_single (last_single),
        .last_pair   (last_pair)
    );

    rdsdec_syndrome u_syn (
        .trial (trial),
        .hit   (syn_hit),
        .kind  (syn_kind),
        .data  (syn_data)
    );

    // Form the trial word and its flip cost for the current stage.
    always_comb begin
        trial      = word_q;
        trial_cost = '0;
        case (state)
            ST_D1: begin
                trial      = word_q ^ (ONE_HOT0 << (BLK_W - 1 - int'(idx_a)));
                trial_cost = COST_W'(conf_q[idx_a]);
            end
            ST_D2: begin
                trial      = word_q ^ (ONE_HOT0 << (BLK_W - 1 - int'(idx_a)))
                                    ^ (ONE_HOT0 << (BLK_W - 1 - int'(idx_b)));
                trial_cost = COST_W'(conf_q[idx_a]) + COST_W'(conf_q[idx_b]);
            end
            default: ;
        endcase
    end

    // Decide whether this trial replaces the best one; strict less-than keeps the earliest on a tie.
    always_comb begin
        prune     = (state == ST_D2) && best_found && (trial_cost >= best_cost);
        take      = (state == ST_D1 || state == ST_D2) && syn_hit && !prune
                    && (!best_found || trial_cost < best_cost);
        nxt_found = best_found | take;
        nxt_cost  = take ? trial_cost : best_cost;
        nxt_data  = take ? syn_data   : best_data;
        nxt_kind  = take ? syn_kind   : best_kind;
    end

    // Sequence the search stages and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            word_q     <= '0;
            for (int k = 0; k < BLK_W; k++) conf_q[k] <= '0;
            best_found <= 1'b0;
            best_cost  <= COST_NONE;
            best_data  <= '0;
            best_kind  <= KIND_A;
            busy       <= 1'b0;
            done       <= 1'b0;
            ok         <= 1'b0;
            data_out   <= '0;
            kind_out   <= '0;
            cost_out   <= COST_NONE;
        end else begin
            done       <= 1'b0;
            best_found <= nxt_found;
            best_cost  <= nxt_cost;
            best_data  <= nxt_data;
            best_kind  <= nxt_kind;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        word_q <= word_in;
                        for (int k = 0; k < BLK_W; k++)
                            conf_q[k] <= conf_in[k*CONF_W +: CONF_W];
                        best_found <= 1'b0;
                        best_cost  <= COST_NONE;
                        busy       <= 1'b1;
                        state      <= ST_D0;
                    end
                end
                ST_D0: begin
                    if (syn_hit) begin
                        state    <= ST_IDLE;
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        ok       <= 1'b1;
                        data_out <= syn_data;
                        kind_out <= syn_kind;
                        cost_out <= '0;
                    end else begin
                        state <= ST_D1;
                    end
                end
                ST_D1: begin
                    if (last_single) begin
                        if (nxt_found) begin
                            state    <= ST_IDLE;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                            ok       <= 1'b1;
                            data_out <= nxt_data;
                            kind_out <= nxt_kind;
                            cost_out <= nxt_cost;
                        end else begin
                            state <= ST_D2;
                        end
                    end
                end
                ST_D2: begin
                    if (last_pair) begin
                        state    <= ST_IDLE;
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        ok       <= nxt_found;
                        data_out <= nxt_found ? nxt_data : '0;
                        kind_out <= nxt_found ? nxt_kind : 3'd0;
                        cost_out <= nxt_found ? nxt_cost : COST_NONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rdsdec_checker.sv
// Protocol and result checks for the soft block decoder, attached by bind.
// Assumes the top module's port names.
module rdsdec_checker #(
    parameter int CONF_W = 8,
    localparam int COST_W = CONF_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ok,
    input logic [15:0]       data_out,
    input logic [2:0]        kind_out,
    input logic [COST_W-1:0] cost_out
);

    localparam int MAX_LAT = 352;

    logic [9:0] lat_cnt;

    // Count the cycles spent busy so the latency bound can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat_cnt <= '0;
        else if (busy) lat_cnt <= lat_cnt + 10'd1;
        else           lat_cnt <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ok) && $stable(data_out) && $stable(kind_out) && $stable(cost_out))); // R9
    AST_FAIL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (data_out == 16'd0 && kind_out == 3'd0 && cost_out == {COST_W{1'b1}})); // R8
    AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (done && ok) |-> (kind_out <= 3'd4)); // R3
    AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) lat_cnt <= 10'(MAX_LAT)); // R11

endmodule

bind rds_soft_block_dec rdsdec_checker #(.CONF_W(CONF_W)) u_rdsdec_checker (.*);

// File: tb/test_rds_soft_block_dec.sv
// Self-checking bench: a brute-force reference search computed from the requirements.
module test_rds_soft_block_dec;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 26;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NB-1:0]   word_in = '0;
    logic [NB*CW-1:0] conf_in = '0;
    logic            busy, done, ok;
    logic [15:0]     data_out;
    logic [2:0]      kind_out;
    logic [8:0]      cost_out;

    int n_total = 0;
    int n_pass  = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1357_9bdf;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rds_soft_block_dec i_rds_soft_block_dec (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in), .conf_in(conf_in),
        .busy(busy), .done(done), .ok(ok), .data_out(data_out), .kind_out(kind_out),
        .cost_out(cost_out)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // Remainder of a full 26-bit word by long division (R3).
    function automatic logic [9:0] rem26(input logic [25:0] w);
        logic [25:0] r;
        r = w;
        for (int i = 25; i >= 10; i--)
            if (r[i]) r = r ^ (26'h5B9 << (i - 10));
        return r[9:0];
    endfunction

    function automatic int kind_of(input logic [25:0] w);
        case (rem26(w))
            10'h0FC: return 0;
            10'h198: return 1;
            10'h168: return 2;
            10'h350: return 3;
            10'h1B4: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [9:0] ofs(input int k);
        case (k)
            0: return 10'h0FC;
            1: return 10'h198;
            2: return 10'h168;
            3: return 10'h350;
            default: return 10'h1B4;
        endcase
    endfunction

    function automatic logic [25:0] enc(input logic [15:0] d, input int k);
        return {d, rem26({d, 10'b0}) ^ ofs(k)};
    endfunction

    function automatic logic [25:0] flip(input logic [25:0] w, input int k);
        return w ^ (26'd1 << (25 - k));
    endfunction

    // Reference search: distance 0, singles, then pairs, earliest on a tie.
    task automatic model(input logic [25:0] w, input logic [NB*CW-1:0] cb,
                         output bit m_ok, output logic [15:0] m_data, output int m_kind,
                         output int m_cost, output int m_dist);
        int best;
        logic [25:0] t;
        m_ok = 0; m_data = '0; m_kind = 0; m_cost = 511; m_dist = 3;
        if (kind_of(w) >= 0) begin
            m_ok = 1; m_data = w[25:10]; m_kind = kind_of(w); m_cost = 0; m_dist = 0;
            return;
        end
        best = -1;
        for (int k = 0; k < NB; k++) begin
            t = flip(w, k);
            if (kind_of(t) >= 0 && (best < 0 || int'(cb[k*CW +: CW]) < best)) begin
                best = int'(cb[k*CW +: CW]);
                m_ok = 1; m_data = t[25:10]; m_kind = kind_of(t); m_cost = best; m_dist = 1;
            end
        end
        if (m_ok) return;
        for (int i = 0; i < NB; i++)
            for (int j = i + 1; j < NB; j++) begin
                int c;
                c = int'(cb[i*CW +: CW]) + int'(cb[j*CW +: CW]);
                t = flip(flip(w, i), j);
                if (kind_of(t) >= 0 && (best < 0 || c < best)) begin
                    best = c;
                    m_ok = 1; m_data = t[25:10]; m_kind = kind_of(t); m_cost = c; m_dist = 2;
                end
            end
    endtask

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_total++;
        if (cond) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // Run one decode and compare against the reference; optionally poke start while busy.
    task automatic run_case(input logic [25:0] w, input logic [NB*CW-1:0] cb,
                            input string req, input bit poke);
        bit m_ok; logic [15:0] m_data; int m_kind, m_cost, m_dist, cnt, exp_lat;
        model(w, cb, m_ok, m_data, m_kind, m_cost, m_dist);
        @(negedge clk);
        word_in = w; conf_in = cb; start = 1'b1;
        cnt = 0;
        while (1) begin
            @(negedge clk);
            cnt++;
            start = 1'b0;
            if (poke && cnt == 4) begin
                word_in = ~w; conf_in = ~cb; start = 1'b1;
            end
            if (done || cnt > 600) break;
        end
        start = 1'b0;
        exp_lat = (m_dist == 0) ? 1 : (m_dist == 1) ? 27 : 352;
        check(done, "R11", "done seen", done, 1);
        check(cnt - 1 == exp_lat, "R11", "latency", cnt - 1, exp_lat);
        check(ok == m_ok, req, "ok", ok, m_ok);
        check(data_out == m_data && int'(kind_out) == m_kind, req, "data/kind",
              {data_out, 5'd0, kind_out}, {m_data, 5'd0, 3'(m_kind)});
        check(int'(cost_out) == m_cost, req, "cost", cost_out, m_cost);
        @(negedge clk);
        check(!done && !busy, "R9", "idle after done", {busy, done}, 0);
    endtask

    function automatic logic [NB*CW-1:0] conf_fill(input logic [7:0] v);
        logic [NB*CW-1:0] cb;
        for (int k = 0; k < NB; k++) cb[k*CW +: CW] = v;
        return cb;
    endfunction

    function automatic logic [NB*CW-1:0] conf_rand();
        logic [NB*CW-1:0] cb;
        for (int k = 0; k < NB; k++) cb[k*CW +: CW] = 8'(rnd());
        return cb;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        logic [NB*CW-1:0] cb;
        logic [25:0] w;
        bit m_ok; logic [15:0] m_data; int m_kind, m_cost, m_dist;

        repeat (3) @(negedge clk);
        check(!busy && !done && !ok, "R1", "flags after reset", {busy, done, ok}, 0);
        check(data_out == 0 && kind_out == 0 && cost_out == 9'd511, "R1", "fields after reset",
              cost_out, 511);
        rst_n = 1'b1;

        // R2 / R3: clean blocks of every kind.
        for (int k = 0; k < 5; k++)
            run_case(enc(16'h1234 + 16'(k * 16'h1111), k), conf_rand(), "R2_R3", 0);

        // R4: single errors at spread positions with random reliabilities.
        for (int k = 0; k < NB; k += 5) begin
            cb = conf_rand();
            run_case(flip(enc(16'(rnd()), k % 5), k), cb, "R4", 0);
        end

        // R5: expensive single flip with cheap pairs elsewhere.
        cb = conf_fill(8'd1);
        cb[4*CW +: CW] = 8'd200;
        w = flip(enc(16'h1234, 1), 4);
        model(w, cb, m_ok, m_data, m_kind, m_cost, m_dist);
        check(m_dist == 1, "R5", "reference picks single", m_dist, 1);
        run_case(w, cb, "R5", 0);

        // R6: double errors at low-reliability positions.
        for (int n = 0; n < 6; n++) begin
            int i, j;
            i = n * 3; j = i + 2 + n;
            cb = conf_fill(8'd120);
            cb[i*CW +: CW] = 8'd7; cb[j*CW +: CW] = 8'd9;
            run_case(flip(flip(enc(16'(rnd()), n % 5), i), j), cb, "R6", 0);
        end

        // R7: uniform reliabilities force many ties.
        for (int n = 0; n < 4; n++)
            run_case(flip(flip(flip(enc(16'(rnd()), n), n), 9 + n), 20 + n),
                     conf_fill(8'd5), "R7", 0);

        // R10: pair result at maximum reliability.
        for (int n = 0; n < 60; n++) begin
            w = flip(flip(enc(16'(n * 977), 2), 3), 17);
            model(w, conf_fill(8'd255), m_ok, m_data, m_kind, m_cost, m_dist);
            if (m_dist == 2) break;
        end
        check(m_cost == 510, "R10", "reference pair cost", m_cost, 510);
        run_case(w, conf_fill(8'd255), "R10", 0);

        // R8: search for a word that nothing decodes.
        m_ok = 1;
        for (int n = 0; n < 20000 && m_ok; n++) begin
            w = 26'(rnd());
            model(w, conf_fill(8'd10), m_ok, m_data, m_kind, m_cost, m_dist);
        end
        check(!m_ok, "R8", "failing word found", m_ok, 0);
        run_case(w, conf_fill(8'd10), "R8", 0);

        // R9: start while busy is ignored, in each long stage.
        run_case(flip(enc(16'hBEEF, 4), 2), conf_rand(), "R9", 1);
        run_case(flip(flip(enc(16'h0F0F, 0), 5), 6), conf_fill(8'd30), "R9", 1);
        // R9: results hold while idle.
        repeat (5) @(negedge clk);
        check(!done && !busy, "R9", "held idle", {busy, done}, 0);

        // Mixed random words.
        for (int n = 0; n < 12; n++)
            run_case(26'(rnd()), conf_rand(), "R4_R6", 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule